// File: doc/BRIEF.md
# Phase-Lock Loss Detector with Tolerance Window

This block watches the phase-error pulses produced by a phase detector and decides whether the loop has lost lock. The time base is the block clock. The block measures each error pulse by counting clock cycles while the pulse is high. A pulse that stays high longer than the selected tolerance counts as an unlock event. A 2-bit setting has four meanings: turn detection off, pass the raw error signal straight through, or compare it against a narrow or a wide tolerance.

In the two windowed settings a retriggerable hold timer stretches the unlock indication. The timer counts pulses of a slow reference tick. A short unlock event therefore stays visible on a status pin for between one and two tick periods. With a 1 ms tick that gives the 1 to 2 ms stretch.

The block has two outputs:
- An active-high unlock flag, which drives a status pin low.
- A lock bit, latched when a serial read-back starts, that reads 0 while unlocked.

Top module: `ulk_detector`

## Requirements
- R1: After reset `unlock_flag` is 0 and `lock_bit` is 1.
- R2: With `mode` = 2'b00 (stopped), `unlock_flag` stays 0 whatever `phase_err` does.
- R3: With `mode` = 2'b01 (direct), `unlock_flag` equals the value `phase_err` had at the previous rising clock edge, with no stretching.
- R4: With `mode` = 2'b10 (narrow, `NARROW_CYC` cycles) or 2'b11 (wide, `WIDE_CYC` cycles), a pulse sampled high on at most that many consecutive edges does not set `unlock_flag`.
- R5: In a windowed mode, `unlock_flag` rises right after the edge at which `phase_err` is sampled high for the (window+1)-th consecutive time.
- R6: Once set in a windowed mode, `unlock_flag` stays 1 until `HOLD_TICKS` edges with `ref_tick` high have passed since the last over-width sample. It clears right after the last of those edges.
- R7: An over-width sample while the flag is held reloads the hold count (retrigger).
- R8: A clock edge with `rd_start` high loads `lock_bit` with the inverse of `unlock_flag`. At any other edge `lock_bit` is unchanged.
- R9: Leaving the windowed modes for 2'b00 or 2'b01 clears the pulse counter and the hold timer. A later return to a windowed mode starts with `unlock_flag` at 0.
- R10: Setting 2'b10 uses the narrow window and 2'b11 uses the wide window. A pulse longer than `NARROW_CYC` but no longer than `WIDE_CYC` sets the flag only under 2'b10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the pulse-width time base |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Detection setting: 00 stop, 01 direct, 10 narrow, 11 wide |
| phase_err | input | 1 | Phase-error pulse from the phase detector, synchronous to `clk` |
| ref_tick | input | 1 | One-cycle reference tick that clocks the hold timer |
| rd_start | input | 1 | One-cycle strobe marking the start of a serial read-back |
| unlock_flag | output | 1 | High while an unlock condition is indicated |
| lock_bit | output | 1 | Lock status latched at read-back start (1 = locked) |

## Verification
The properties assume that `phase_err`, `ref_tick` and `rd_start` are already synchronous to `clk`. They also assume that `mode` changes only between edges and then stays put for a few cycles. The rise and fall checks in the windowed modes rely on this, because they require the setting to have held steady over the two preceding edges. The bench drives every input one nanosecond after a rising edge. It holds each setting for many cycles and keeps `ref_tick` low while an error pulse is being measured, so that the reload and decrement effects can be told apart.

// File: rtl/ulk_pkg.sv
package ulk_pkg;

    typedef enum logic [1:0] {
        ULK_STOP   = 2'b00,
        ULK_DIRECT = 2'b01,
        ULK_NARROW = 2'b10,
        ULK_WIDE   = 2'b11
    } ulk_mode_e;

    typedef struct packed {
        logic windowed;
        logic sel_wide;
        logic direct;
    } ulk_ctrl_t;

    function automatic ulk_ctrl_t decode_mode(input ulk_mode_e m);
        ulk_ctrl_t c;
        c.windowed = (m == ULK_NARROW) || (m == ULK_WIDE);
        c.sel_wide = (m == ULK_WIDE);
        c.direct   = (m == ULK_DIRECT);
        return c;
    endfunction

endpackage

// File: rtl/ulk_width_meter.sv
module ulk_width_meter
    import ulk_pkg::*;
#(
    parameter int NARROW_CYC = 69,
    parameter int WIDE_CYC   = 139
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic sel_wide,
    input  logic phase_err,
    output logic over_width
);
    localparam int CW = $clog2(WIDE_CYC + 1);
    localparam logic [CW-1:0] LIM_N = CW'(NARROW_CYC);
    localparam logic [CW-1:0] LIM_W = CW'(WIDE_CYC);

    logic [CW-1:0] run_q;
    logic [CW-1:0] limit;

    always_comb begin
        limit      = sel_wide ? LIM_W : LIM_N;
        over_width = enable && phase_err && (run_q >= limit);
    end

    // Count consecutive high samples, saturating at the wide limit.
    always_ff @(posedge clk) begin
        if (rst || !enable || !phase_err) begin
            run_q <= '0;
        end else if (run_q < LIM_W) begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/ulk_stretch.sv
module ulk_stretch #(
    parameter int HOLD_TICKS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic trigger,
    input  logic tick,
    output logic active
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] RELOAD = HW'(HOLD_TICKS);

    logic [HW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            left_q <= '0;
        end else if (trigger) begin
            left_q <= RELOAD;
        end else if (tick && (left_q != '0)) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/ulk_readback.sv
module ulk_readback (
    input  logic clk,
    input  logic rst,
    input  logic capture,
    input  logic unlocked,
    output logic lock_bit
);
    always_ff @(posedge clk) begin
        if (rst) begin
            lock_bit <= 1'b1;
        end else if (capture) begin
            lock_bit <= ~unlocked;
        end
    end
endmodule

// File: rtl/ulk_detector.sv
module ulk_detector
    import ulk_pkg::*;
#(
    parameter int NARROW_CYC = 69,
    parameter int WIDE_CYC   = 139,
    parameter int HOLD_TICKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       phase_err,
    input  logic       ref_tick,
    input  logic       rd_start,
    output logic       unlock_flag,
    output logic       lock_bit
);
    ulk_ctrl_t ctrl;
    logic      over_width;
    logic      held;
    logic      direct_q;

    assign ctrl = decode_mode(ulk_mode_e'(mode));

    ulk_width_meter #(
        .NARROW_CYC(NARROW_CYC),
        .WIDE_CYC  (WIDE_CYC)
    ) u_meter (
        .clk       (clk),
        .rst       (rst),
        .enable    (ctrl.windowed),
        .sel_wide  (ctrl.sel_wide),
        .phase_err (phase_err),
        .over_width(over_width)
    );

    ulk_stretch #(
        .HOLD_TICKS(HOLD_TICKS)
    ) u_stretch (
        .clk    (clk),
        .rst    (rst),
        .enable (ctrl.windowed),
        .trigger(over_width),
        .tick   (ref_tick),
        .active (held)
    );

    always_ff @(posedge clk) begin
        if (rst || !ctrl.direct) begin
            direct_q <= 1'b0;
        end else begin
            direct_q <= phase_err;
        end
    end

    always_comb begin
        if (ctrl.windowed)    unlock_flag = held;
        else if (ctrl.direct) unlock_flag = direct_q;
        else                  unlock_flag = 1'b0;
    end

    ulk_readback u_rb (
        .clk     (clk),
        .rst     (rst),
        .capture (rd_start),
        .unlocked(unlock_flag),
        .lock_bit(lock_bit)
    );
endmodule

// File: rtl/ulk_detector_chk.sv
module ulk_detector_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       phase_err,
    input logic       ref_tick,
    input logic       rd_start,
    input logic       unlock_flag,
    input logic       lock_bit
);
    // R3: direct mode delays the error by one edge
    a_r3_direct_follow: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && mode == 2'b01 && $past(mode) == 2'b01)
            |-> unlock_flag == $past(phase_err));

    // R5: in a windowed mode the flag only rises after a high error sample
    a_r5_rise_needs_err: assert property (@(posedge clk) disable iff (rst)
        ($rose(unlock_flag) && mode[1] && $past(mode) == mode && $past(mode, 2) == mode)
            |-> $past(phase_err));

    // R6: in a windowed mode the flag only falls on a reference tick
    a_r6_fall_on_tick: assert property (@(posedge clk) disable iff (rst)
        ($fell(unlock_flag) && mode[1] && $past(mode) == mode && $past(mode, 2) == mode)
            |-> $past(ref_tick));

    // R8: capture of the inverse flag at read-back start
    a_r8_capture: assert property (@(posedge clk) disable iff (rst)
        rd_start |=> lock_bit == !$past(unlock_flag));

    // R8: lock bit holds between read-backs
    a_r8_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_start |=> $stable(lock_bit));

    // R2: stopped mode keeps the flag inactive
    a_r2_stop_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'b00 && $past(phase_err)) |-> !unlock_flag);
endmodule

bind ulk_detector ulk_detector_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .phase_err  (phase_err),
    .ref_tick   (ref_tick),
    .rd_start   (rd_start),
    .unlock_flag(unlock_flag),
    .lock_bit   (lock_bit)
);

// File: tb/ulk_detector_tb.sv
module ulk_detector_tb;
    localparam int NARROW = 3;
    localparam int WIDE   = 6;
    localparam int HOLD   = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic       phase_err = 1'b0;
    logic       ref_tick = 1'b0;
    logic       rd_start = 1'b0;
    logic       unlock_flag;
    logic       lock_bit;

    always #4 clk = ~clk;

    ulk_detector #(
        .NARROW_CYC(NARROW),
        .WIDE_CYC  (WIDE),
        .HOLD_TICKS(HOLD)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode),
        .phase_err  (phase_err),
        .ref_tick   (ref_tick),
        .rd_start   (rd_start),
        .unlock_flag(unlock_flag),
        .lock_bit   (lock_bit)
    );

    typedef struct {
        string req;
        logic  flag;
        logic  lock;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    logic exp_lock = 1'b1;
    bit done = 0;

    // Monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (unlock_flag !== it.flag || lock_bit !== it.lock) begin
                errors++;
                $display("FAIL %s: flag=%b lock=%b expected flag=%b lock=%b",
                         it.req, unlock_flag, lock_bit, it.flag, it.lock);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_now(input string req, input logic f);
        item_t it;
        it.req = req; it.flag = f; it.lock = exp_lock;
        q.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic pulse(input int n);
        phase_err = 1'b1;
        step(n);
        phase_err = 1'b0;
    endtask

    task automatic tick_once();
        ref_tick = 1'b1;
        step(1);
        ref_tick = 1'b0;
    endtask

    task automatic readback(input logic cur_flag);
        rd_start = 1'b1;
        step(1);
        rd_start = 1'b0;
        exp_lock = ~cur_flag;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: flag=%b lock=%b expected run to finish", unlock_flag, lock_bit);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        expect_now("R1 reset", 1'b0);

        // R2 stopped mode ignores a long error pulse
        mode = 2'b00;
        phase_err = 1'b1;
        step(10);
        expect_now("R2 stop during pulse", 1'b0);
        phase_err = 1'b0;
        step(1);
        readback(1'b0);
        expect_now("R2 lock bit in stop", 1'b0);

        // R3 direct mode
        mode = 2'b01;
        phase_err = 1'b1;
        step(1);
        expect_now("R3 direct high", 1'b1);
        phase_err = 1'b0;
        step(1);
        expect_now("R3 direct low", 1'b0);

        // R4 narrow pulse at window length
        mode = 2'b10;
        step(2);
        pulse(NARROW);
        step(1);
        expect_now("R4 narrow at limit", 1'b0);

        // R5 narrow over-width
        phase_err = 1'b1;
        step(NARROW);
        expect_now("R5 before over", 1'b0);
        step(1);
        phase_err = 1'b0;
        expect_now("R5 over-width sets", 1'b1);

        // R8 read back while unlocked
        readback(1'b1);
        expect_now("R8 lock reads 0", 1'b1);

        // R6 hold over ticks
        step(5);
        expect_now("R6 held without ticks", 1'b1);
        tick_once();
        expect_now("R6 after first tick", 1'b1);

        // R7 retrigger reloads
        pulse(NARROW + 1);
        tick_once();
        expect_now("R7 reloaded after one tick", 1'b1);
        tick_once();
        expect_now("R6 clears after hold", 1'b0);

        readback(1'b0);
        expect_now("R8 lock reads 1", 1'b0);

        // R10 wide window
        mode = 2'b11;
        step(2);
        pulse(NARROW + 1);
        step(1);
        expect_now("R10 mid pulse ignored by wide", 1'b0);
        pulse(WIDE);
        step(1);
        expect_now("R4 wide at limit", 1'b0);
        pulse(WIDE + 1);
        expect_now("R5 wide over-width", 1'b1);

        // R9 leaving windowed modes clears hold
        mode = 2'b01;
        step(1);
        expect_now("R9 direct after switch", 1'b0);
        mode = 2'b10;
        step(1);
        expect_now("R9 windowed restart clear", 1'b0);

        // R9 partial count is discarded on mode change
        phase_err = 1'b1;
        step(NARROW);
        mode = 2'b00;
        step(1);
        mode = 2'b10;
        step(1);
        phase_err = 1'b0;
        step(1);
        expect_now("R9 counter cleared", 1'b0);

        done = 1;
        step(2);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule